// File: doc/BRIEF.md
# Transmit FIFO Start-Threshold Controller

This block holds the bytes of outgoing frames between a system-bus writer and a serial frame transmitter, and it decides when the transmitter may begin sending a frame. Sending does not wait for a complete frame. It begins when the first of three things happens: the number of bytes buffered for the frame reaches a programmable threshold, the frame's end-of-frame byte has been written, or the FIFO has filled up.

Each FIFO entry holds a data byte and an end-of-frame tag. The writer pushes entries. Once the block raises `tx_start`, the transmitter pulls bytes one at a time with `rd_req`. `tx_start` stays high until the transmitter has taken the tagged byte that ends the frame.

Software reaches two registers through a simple select/write port with combinational read-back:
- A 2-bit threshold code.
- A FIFO start-address register whose value can never go below its reset value.

The block also reports two error conditions:
- A one-cycle underrun pulse when the transmitter asks for a byte that is not there yet.
- A sticky overflow bit when the writer pushes into a full FIFO.

Top module: `tx_thresh_fifo`

## Requirements
- R1: After reset, `tx_start`, `underrun`, `overflow`, `rd_valid` and `level` are 0. The threshold register (`reg_sel`=0) reads 0 and the start-address register (`reg_sel`=1) reads `BASE_RST`.
- R2: The threshold register keeps only `reg_wdata[1:0]`. Bits 31:2 always read back as zero.
- R3: Threshold code 2'b00 or 2'b01 selects `WM_UNIT` bytes, 2'b10 selects 2·`WM_UNIT` and 2'b11 selects 3·`WM_UNIT`. `tx_start` rises one cycle after the write that brings `level` up to the selected count, and not while `level` is below it.
- R4: `tx_start` rises one cycle after an entry tagged end-of-frame is written, even when fewer bytes than the threshold are buffered.
- R5: `tx_start` rises one cycle after the FIFO becomes full (`level` = `DEPTH`), even when the threshold is larger than `DEPTH`.
- R6: The start-address register takes `reg_wdata[BASE_W-1:0]`. A value below `BASE_RST` is stored as `BASE_RST`. Upper bits read as zero.
- R7: Once high, `tx_start` stays high until a read that pops an entry tagged end-of-frame. It is low right after that edge.
- R8: The threshold in force for a frame is sampled while the FIFO is idle (empty and not started). A code written after the frame's first byte applies only to the next frame.
- R9: A `rd_req` while `tx_start` is high and the FIFO is empty raises `underrun` for the cycle after that request.
- R10: A write while the FIFO is full is discarded, leaves `level` unchanged, and sets `overflow`. `overflow` stays set until reset.
- R11: `rd_valid` is high only while `tx_start` is high and the FIFO is non-empty. Entries come out in write order, with `rd_data` and the tag on `rd_eof` as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 threshold code, 1 start address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read-back of the selected register |
| wr_en | input | 1 | Push one entry |
| wr_data | input | 8 | Byte to push |
| wr_eof | input | 1 | Tag the pushed byte as end of frame |
| rd_req | input | 1 | Transmitter byte request |
| rd_valid | output | 1 | Head entry is available to the transmitter |
| rd_data | output | 8 | Head byte |
| rd_eof | output | 1 | Head entry's end-of-frame tag |
| tx_start | output | 1 | Frame transmission may proceed |
| underrun | output | 1 | One-cycle pulse: byte requested from an empty FIFO mid-frame |
| overflow | output | 1 | Sticky: a write hit a full FIFO |
| level | output | $clog2(DEPTH+1) | Number of stored entries |

## Verification
The bench builds the block with `DEPTH`=16 and `WM_UNIT`=8, which gives thresholds of 8, 16 and 24 bytes. The 24-byte code therefore exceeds the FIFO size, so the only way that frame can start is by filling the FIFO. The 16-byte code coincides with full. With these values, every release path, the wrap of the pointers, overflow on a full FIFO, and a mid-frame threshold change each take only a few dozen cycles to reach.

// File: rtl/tx_thresh_fifo.sv
module tx_thresh_fifo #(
  parameter int DEPTH    = 256,
  parameter int WM_UNIT  = 64,
  parameter int BASE_W   = 16,
  parameter logic [BASE_W-1:0] BASE_RST = 16'h0040
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_we,
  input  logic                         reg_sel,
  input  logic [31:0]                  reg_wdata,
  output logic [31:0]                  reg_rdata,
  input  logic                         wr_en,
  input  logic [7:0]                   wr_data,
  input  logic                         wr_eof,
  input  logic                         rd_req,
  output logic                         rd_valid,
  output logic [7:0]                   rd_data,
  output logic                         rd_eof,
  output logic                         tx_start,
  output logic                         underrun,
  output logic                         overflow,
  output logic [$clog2(DEPTH+1)-1:0]   level
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = $clog2(DEPTH+1);
  localparam int THR_W = $clog2(3*WM_UNIT+1);

  logic [8:0]        mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic [LVL_W-1:0]  eof_cnt;
  logic [1:0]        wm_q;
  logic [BASE_W-1:0] base_q;
  logic [THR_W-1:0]  thr_q;
  logic [BASE_W-1:0] base_in;

  function automatic logic [THR_W-1:0] thr_of(input logic [1:0] code);
    case (code)
      2'b10:   thr_of = THR_W'(2*WM_UNIT);
      2'b11:   thr_of = THR_W'(3*WM_UNIT);
      default: thr_of = THR_W'(WM_UNIT);
    endcase
  endfunction

  wire full       = (level == LVL_W'(DEPTH));
  wire empty      = (level == '0);
  wire push       = wr_en && !full;
  wire pop        = rd_req && rd_valid;
  wire pop_eof    = pop && mem[rptr][8];
  wire start_cond = (eof_cnt != '0) || (32'(level) >= 32'(thr_q)) || full;

  assign rd_valid  = tx_start && !empty;
  assign rd_data   = mem[rptr][7:0];
  assign rd_eof    = mem[rptr][8];
  assign base_in   = reg_wdata[BASE_W-1:0];
  assign reg_rdata = reg_sel ? 32'(base_q) : {30'b0, wm_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wm_q   <= '0;
      base_q <= BASE_RST;
    end else if (reg_we) begin
      if (reg_sel) base_q <= (base_in < BASE_RST) ? BASE_RST : base_in;
      else         wm_q   <= reg_wdata[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= {wr_eof, wr_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      level    <= '0;
      eof_cnt  <= '0;
      thr_q    <= thr_of(2'b00);
      tx_start <= 1'b0;
      underrun <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      level   <= level + LVL_W'(push) - LVL_W'(pop);
      eof_cnt <= eof_cnt + LVL_W'(push && wr_eof) - LVL_W'(pop_eof);
      if ((!tx_start && empty) || pop_eof) thr_q <= thr_of(wm_q);
      if (pop_eof)         tx_start <= 1'b0;
      else if (start_cond) tx_start <= 1'b1;
      underrun <= tx_start && rd_req && empty;
      if (wr_en && full) overflow <= 1'b1;
    end
  end

  // R7
  start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start && !pop_eof |=> tx_start);

  // R9
  underrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> $past(tx_start && rd_req && level == '0));

  // R10
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R10
  full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && full && !rd_req |=> $stable(level));

  // R6
  base_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> reg_rdata >= 32'(BASE_RST));

  // R11
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(level) <= DEPTH);

endmodule

// File: tb/tx_thresh_fifo_tb.sv
module tx_thresh_fifo_tb;
  localparam int DEPTH = 16;
  localparam int UNIT  = 8;
  localparam int LW    = $clog2(DEPTH+1);
  localparam logic [15:0] BRST = 16'h0040;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0, reg_sel = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic wr_en = 0, wr_eof = 0, rd_req = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic rd_valid, rd_eof, tx_start, underrun, overflow;
  logic [LW-1:0] level;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  tx_thresh_fifo #(.DEPTH(DEPTH), .WM_UNIT(UNIT), .BASE_W(16), .BASE_RST(BRST)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .wr_en(wr_en), .wr_data(wr_data), .wr_eof(wr_eof),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data), .rd_eof(rd_eof),
    .tx_start(tx_start), .underrun(underrun), .overflow(overflow), .level(level));

  // {code[1:0], bytes[4:0], expected tx_start}
  localparam logic [7:0] VEC [8] = '{
    {2'd0, 5'd7, 1'b0}, {2'd0, 5'd8, 1'b1}, {2'd1, 5'd7, 1'b0}, {2'd1, 5'd8, 1'b1},
    {2'd2, 5'd15, 1'b0}, {2'd2, 5'd16, 1'b1}, {2'd3, 5'd15, 1'b0}, {2'd3, 5'd16, 1'b1}};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic sel, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic reg_rd(input logic sel, output logic [31:0] d);
    @(negedge clk); reg_sel = sel; #1 d = reg_rdata;
  endtask

  task automatic push(input logic [7:0] d, input logic e);
    @(negedge clk); wr_en = 1; wr_data = d; wr_eof = e;
    @(negedge clk); wr_en = 0; wr_eof = 0;
  endtask

  task automatic pop(output logic [7:0] d, output logic e);
    @(negedge clk); d = rd_data; e = rd_eof; rd_req = 1;
    @(negedge clk); rd_req = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1; @(negedge clk);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [7:0] d;
    logic e;
    do_reset();
    // R1 reset state
    chk(tx_start == 0 && underrun == 0 && overflow == 0, "R1 flags", {tx_start, underrun, overflow}, 0);
    chk(level == 0 && rd_valid == 0, "R1 level", level, 0);
    reg_rd(0, r); chk(r == 0, "R1 wm reset", r, 0);
    reg_rd(1, r); chk(r == 32'(BRST), "R1 base reset", r, BRST);

    // R2 reserved bits
    reg_wr(0, 32'hFFFF_FFFE); reg_rd(0, r); chk(r == 32'h2, "R2 reserved", r, 2);

    // R6 clamp
    reg_wr(1, 32'h0000_0010); reg_rd(1, r); chk(r == 32'(BRST), "R6 below", r, BRST);
    reg_wr(1, 32'hABCD_0123); reg_rd(1, r); chk(r == 32'h0123, "R6 above", r, 32'h0123);
    reg_wr(1, 32'(BRST)); reg_rd(1, r); chk(r == 32'(BRST), "R6 equal", r, BRST);

    // R3/R5 vector table
    for (int v = 0; v < 8; v++) begin
      int n;
      n = int'(VEC[v][5:1]);
      reg_wr(0, 32'(VEC[v][7:6]));
      for (int i = 0; i < n; i++) push(8'(v*16 + i), 0);
      @(negedge clk);
      chk(tx_start == VEC[v][0], $sformatf("R3 R5 vec%0d start", v), tx_start, VEC[v][0]);
      chk(32'(level) == 32'(n), $sformatf("R3 vec%0d level", v), level, n);
      if (tx_start) begin
        for (int i = 0; i < n; i++) pop(d, e);
        push(8'hEE, 1); @(negedge clk); pop(d, e);
      end else begin
        chk(rd_valid == 0, "R11 no valid before start", rd_valid, 0);
        push(8'hEE, 1); @(negedge clk);
        chk(tx_start == 1, "R4 eof start", tx_start, 1);
        for (int i = 0; i <= n; i++) pop(d, e);
      end
      chk(tx_start == 0 && level == 0, $sformatf("R7 vec%0d end", v), {tx_start, level}, 0);
    end

    // R4 + R11 order and tags, R7 hold
    reg_wr(0, 0);
    push(8'h11, 0); push(8'h22, 0); push(8'h33, 1);
    @(negedge clk);
    chk(tx_start == 1, "R4 short frame", tx_start, 1);
    pop(d, e); chk(d == 8'h11 && e == 0, "R11 first", {e, d}, 9'h011);
    pop(d, e); chk(d == 8'h22 && e == 0, "R11 second", {e, d}, 9'h022);
    chk(tx_start == 1, "R7 hold mid-frame", tx_start, 1);
    pop(d, e); chk(d == 8'h33 && e == 1, "R11 eof tag", {e, d}, 9'h133);
    chk(tx_start == 0, "R7 fall after eof", tx_start, 1'b0);

    // R8 mid-frame threshold change
    reg_wr(0, 0);
    push(8'h01, 0); push(8'h02, 0);
    reg_wr(0, 3);
    for (int i = 0; i < 6; i++) push(8'(i), 0);
    @(negedge clk);
    chk(tx_start == 1, "R8 old threshold kept", tx_start, 1);
    for (int i = 0; i < 8; i++) pop(d, e);
    // R9 underrun
    @(negedge clk); rd_req = 1;
    @(negedge clk); rd_req = 0;
    chk(underrun == 1, "R9 underrun pulse", underrun, 1);
    @(negedge clk);
    chk(underrun == 0, "R9 underrun one cycle", underrun, 0);
    push(8'hEE, 1); @(negedge clk); pop(d, e);
    chk(tx_start == 0, "R7 frame closed", tx_start, 0);
    for (int i = 0; i < 8; i++) push(8'(i), 0);
    @(negedge clk);
    chk(tx_start == 0, "R8 new threshold next frame", tx_start, 0);
    push(8'hEE, 1); @(negedge clk);
    for (int i = 0; i < 9; i++) pop(d, e);

    // R10 overflow
    reg_wr(0, 3);
    for (int i = 0; i < DEPTH; i++) push(8'(8'h40 + i), 0);
    chk(overflow == 0, "R10 no overflow yet", overflow, 0);
    push(8'hAA, 1);
    chk(overflow == 1 && 32'(level) == DEPTH, "R10 full write", {overflow, level}, {1'b1, LW'(DEPTH)});
    @(negedge clk);
    chk(tx_start == 1, "R5 full start", tx_start, 1);
    for (int i = 0; i < DEPTH; i++) begin
      pop(d, e);
      if (i == DEPTH-1) chk(d == 8'(8'h40 + i) && e == 0, "R10 write discarded", {e, d}, 8'h40 + i);
    end
    chk(tx_start == 1 && level == 0, "R7 no eof yet", {tx_start, level}, {1'b1, LW'(0)});
    push(8'hEE, 1); @(negedge clk); pop(d, e);
    chk(overflow == 1, "R10 sticky", overflow, 1);
    do_reset();
    chk(overflow == 0, "R1 overflow cleared by reset", overflow, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule